// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block reads a sixteen-key matrix arranged as four columns and four rows. It drives the columns low (active low) and reads the row lines back. The rows idle high through external pull-ups, and a closed key pulls its row low while its column is driven. While idle, the block drives every column low at once, so that any closed key shows up on the rows. Before it accepts a press, it must see a fully released matrix.

When a closure appears, the block waits out a debounce interval and samples the rows again. If the closure is gone, it goes back to waiting. If the closure is still there, it drives one column low at a time, starting from column 0. It waits a settle time on each column and then looks at the rows, taking the lowest row that reads low. The key number is `column*4 + row`. It is reported as an ASCII hex character, together with a single-cycle strobe. The block then demands a full release before the next press can be reported.

Row inputs pass through a two-flop synchronizer. The debounce and settle times are parameters counted in clock cycles.

Top module: `keypad_scan`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `col_n` is 4'b0000, `key_valid` is 0 and `key_code` is 8'h00.
- R2: Whenever the block is not scanning, all four columns are driven low (`col_n` = 4'b0000).
- R3: A key that is already closed when reset ends, or that stays closed after a report, produces no code until every row has read high for a settle interval.
- R4: A closure that is gone again when the debounce interval ends produces no code, and the block returns to waiting with all columns low.
- R5: During a scan, exactly one column is low at a time. The order is `col_n` = 1110, 1101, 1011, 0111, after which all columns return low.
- R6: The reported code for key index k = column*4 + row is 8'h30+k for k from 0 to 9, and 8'h41+(k-10) for k from 10 to 15 (ASCII '0'-'9', 'A'-'F').
- R7: Each confirmed press raises `key_valid` for exactly one clock cycle. A held key produces no further strobe.
- R8: Several closed keys in one column report the lowest row. Keys in different columns report the lowest column.
- R9: If a closure disappears during the scan, so that no column finds a key, no code is reported and the block restarts with the release check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | 4 | Raw row return lines, low when a key in a driven column is closed |
| col_n | output | 4 | Column drives, active low, registered |
| key_code | output | 8 | ASCII code of the last confirmed key, held between reports |
| key_valid | output | 1 | One-cycle strobe marking a new `key_code` |

## Verification
The bench presses every one of the sixteen keys and checks the column-major index and the ASCII mapping. A swapped row/column index, or a mapping with an off-by-one at the '9' to 'A' boundary, would report a wrong character. A key held through reset or after a report must stay silent. A design that skipped the release check would emit a code at once or repeat the code. Short bounces shorter than the debounce interval, keys released mid-scan, and two-key patterns are also exercised. A weak debounce or scan-exit path would produce spurious codes, and a reversed priority would report the wrong key of the pair. The column sequence of a full scan is logged to catch wrong scan order or overlapping drives.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {
    ST_RELEASE  = 2'd0,
    ST_WAIT     = 2'd1,
    ST_DEBOUNCE = 2'd2,
    ST_SCAN     = 2'd3
  } kp_state_t;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
        end else begin
          s1 <= din[i];
          s2 <= s1;
        end
      end
      assign dout[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/kp_timer.sv
module kp_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= W'(RESET_VAL);
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/kp_row_prio.sv
module kp_row_prio #(
  parameter int ROWS = 4,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] rows_n,
  output logic            hit,
  output logic [RW-1:0]   row
);
  always_comb begin
    hit = 1'b0;
    row = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (!rows_n[r]) begin
        hit = 1'b1;
        row = RW'(r);
      end
    end
  end
endmodule

// File: rtl/kp_encode.sv
module kp_encode #(
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] idx,
  output logic [7:0]      code
);
  logic [7:0] ext;
  always_comb begin
    ext  = 8'(idx);
    code = (ext < 8'd10) ? (ext + 8'h30) : (ext + 8'h37);
  end
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
  import kp_pkg::*;
#(
  parameter int ROWS            = 4,
  parameter int COLS            = 4,
  parameter int DEBOUNCE_CYCLES = 20000,
  parameter int SETTLE_CYCLES   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_in,
  output logic [COLS-1:0] col_n,
  output logic [7:0]      key_code,
  output logic            key_valid
);
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int IDXW  = $clog2(ROWS * COLS);
  localparam int TMAX  = (DEBOUNCE_CYCLES > SETTLE_CYCLES) ? DEBOUNCE_CYCLES : SETTLE_CYCLES;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] DEB_LOAD = TW'(DEBOUNCE_CYCLES - 1);
  localparam logic [TW-1:0] SET_LOAD = TW'(SETTLE_CYCLES - 1);

  logic [ROWS-1:0] rows_s;
  logic            any_low;
  logic            tmr_load, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            row_hit;
  logic [RW-1:0]   row_idx;
  logic [IDXW-1:0] key_idx;
  logic [7:0]      code_c;

  kp_state_t       state, state_d;
  logic [CW-1:0]   col, col_d;
  logic [COLS-1:0] col_n_d;
  logic            emit;

  kp_sync #(.WIDTH(ROWS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (row_in),
    .dout (rows_s)
  );

  kp_timer #(.W(TW), .RESET_VAL(SETTLE_CYCLES - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  kp_row_prio #(.ROWS(ROWS)) u_prio (
    .rows_n (rows_s),
    .hit    (row_hit),
    .row    (row_idx)
  );

  assign key_idx = IDXW'(col) * IDXW'(ROWS) + IDXW'(row_idx);

  kp_encode #(.IDXW(IDXW)) u_enc (
    .idx  (key_idx),
    .code (code_c)
  );

  assign any_low = ~&rows_s;

  // next-state and timer control
  always_comb begin
    state_d  = state;
    col_d    = col;
    tmr_load = 1'b0;
    tmr_val  = SET_LOAD;
    emit     = 1'b0;
    unique case (state)
      ST_RELEASE: begin
        if (any_low) begin
          tmr_load = 1'b1;
          tmr_val  = SET_LOAD;
        end else if (tmr_zero) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (any_low) begin
          state_d  = ST_DEBOUNCE;
          tmr_load = 1'b1;
          tmr_val  = DEB_LOAD;
        end
      end
      ST_DEBOUNCE: begin
        if (tmr_zero) begin
          if (any_low) begin
            state_d  = ST_SCAN;
            col_d    = '0;
            tmr_load = 1'b1;
            tmr_val  = SET_LOAD;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_SCAN: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = SET_LOAD;
          if (row_hit) begin
            emit    = 1'b1;
            state_d = ST_RELEASE;
          end else if (col == CW'(COLS - 1)) begin
            state_d = ST_RELEASE;
          end else begin
            col_d = col + 1'b1;
          end
        end
      end
      default: state_d = ST_RELEASE;
    endcase
  end

  always_comb begin
    col_n_d = '0;
    if (state_d == ST_SCAN) begin
      col_n_d = '1;
      col_n_d[col_d] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RELEASE;
      col       <= '0;
      col_n     <= '0;
      key_code  <= 8'h00;
      key_valid <= 1'b0;
    end else begin
      state     <= state_d;
      col       <= col_d;
      col_n     <= col_n_d;
      key_valid <= emit;
      if (emit) key_code <= code_c;
    end
  end
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int COLS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [COLS-1:0] col_n,
  input logic [7:0]      key_code,
  input logic            key_valid
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (col_n == '0 && !key_valid && key_code == 8'h00)); // R1

  AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (rst)
    (col_n == '0) || ($countones(~col_n) == 1)); // R5

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid); // R7

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> ((key_code >= 8'h30 && key_code <= 8'h39) ||
                   (key_code >= 8'h41 && key_code <= 8'h46))); // R6

  AST_REPORT_FROM_SCAN: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> ($past(col_n) != '0 && col_n == '0)); // R2
endmodule

bind keypad_scan kp_checker #(.COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .col_n     (col_n),
  .key_code  (key_code),
  .key_valid (key_valid)
);

// File: tb/keypad_scan_test.sv
`timescale 1ns/1ps
module keypad_scan_test;
  localparam int DEB = 20;
  localparam int SET = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in;
  logic [3:0] col_n;
  logic [7:0] key_code;
  logic       key_valid;
  logic [15:0] pressed = '0;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  int width_err = 0;
  logic [7:0] last_code = 8'h00;
  logic prev_valid = 1'b0;
  int cyc = 0;
  bit finished = 1'b0;

  logic       log_en = 1'b0;
  logic [3:0] log_q [8];
  int         log_n = 0;
  logic [3:0] log_last = 4'b0000;

  always #4 clk = ~clk;

  keypad_scan #(.ROWS(4), .COLS(4), .DEBOUNCE_CYCLES(DEB), .SETTLE_CYCLES(SET)) uut (
    .clk(clk), .rst(rst), .row_in(row_in),
    .col_n(col_n), .key_code(key_code), .key_valid(key_valid)
  );

  // key matrix model: row r low if a closed key sits in a driven column
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < 4; c++)
        if (pressed[c*4+r] && !col_n[c]) row_in[r] = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      prev_valid = 1'b0;
    end else begin
      if (key_valid) begin
        vcount++;
        last_code = key_code;
        if (prev_valid) width_err++;
      end
      prev_valid = key_valid;
    end
    if (log_en && col_n != log_last) begin
      if (log_n < 8) log_q[log_n] = col_n;
      log_n++;
      log_last = col_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_code(input int k);
    return (k < 10) ? 8'(8'h30 + k) : 8'(8'h41 + k - 10);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    pressed = '0;
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    check(col_n == 4'b0000, "R1", "cols in reset", col_n, 0);
    check(key_valid == 1'b0, "R1", "valid in reset", key_valid, 0);
    check(key_code == 8'h00, "R1", "code in reset", key_code, 0);
    rst = 1'b0;
    @(negedge clk);
    check(col_n == 4'b0000 && !key_valid, "R1", "after reset", {col_n, 3'b0, key_valid}, 0);
  endtask

  task automatic t_idle();
    int v0 = vcount;
    wait_cyc(60);
    check(col_n == 4'b0000, "R2", "idle cols", col_n, 0);
    check(vcount == v0, "R2", "idle strobes", vcount - v0, 0);
  endtask

  task automatic t_all_keys();
    for (int k = 0; k < 16; k++) begin
      int v0 = vcount;
      pressed = 16'(1) << k;
      wait_cyc(150);
      check(vcount == v0 + 1 && last_code == exp_code(k), "R6",
            $sformatf("key %0d code", k), last_code, exp_code(k));
      pressed = '0;
      wait_cyc(40);
    end
  endtask

  task automatic t_held();
    int v0 = vcount;
    pressed = 16'(1) << 5;
    wait_cyc(400);
    check(vcount == v0 + 1, "R7", "held key strobes", vcount - v0, 1);
    check(last_code == 8'h35, "R7", "held key code", last_code, 8'h35);
    check(width_err == 0, "R7", "strobe width errors", width_err, 0);
    check(col_n == 4'b0000, "R3", "waiting for release", col_n, 0);
    pressed = '0;
    wait_cyc(40);
  endtask

  task automatic t_bounce();
    int v0 = vcount;
    pressed = 16'(1) << 3;
    wait_cyc(DEB / 2);
    pressed = '0;
    wait_cyc(120);
    check(vcount == v0, "R4", "short closure strobes", vcount - v0, 0);
    check(col_n == 4'b0000, "R4", "back to waiting", col_n, 0);
    pressed = 16'(1) << 3;
    wait_cyc(150);
    check(vcount == v0 + 1 && last_code == 8'h33, "R4", "press after bounce", last_code, 8'h33);
    pressed = '0;
    wait_cyc(40);
  endtask

  task automatic t_multi();
    pressed = (16'(1) << 6) | (16'(1) << 5);
    wait_cyc(150);
    check(last_code == 8'h35, "R8", "lowest row wins", last_code, 8'h35);
    pressed = '0;
    wait_cyc(40);
    pressed = (16'(1) << 9) | (16'(1) << 7);
    wait_cyc(150);
    check(last_code == 8'h37, "R8", "lowest column wins", last_code, 8'h37);
    pressed = '0;
    wait_cyc(40);
  endtask

  task automatic t_scan_order();
    logic [3:0] exp_seq [5] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b0000};
    bit ok = 1'b1;
    log_n = 0;
    log_last = col_n;
    log_en = 1'b1;
    pressed = 16'(1) << 15;
    wait_cyc(150);
    log_en = 1'b0;
    for (int i = 0; i < 5; i++)
      if (log_n < 5 || log_q[i] != exp_seq[i]) ok = 1'b0;
    check(ok && log_n == 5, "R5", "column scan order", log_n, 5);
    check(last_code == 8'h46, "R6", "key 15 code", last_code, 8'h46);
    pressed = '0;
    wait_cyc(40);
  endtask

  task automatic t_gone_in_scan();
    int v0 = vcount;
    int guard = 0;
    pressed = 16'(1) << 12;
    while (col_n != 4'b1110 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    pressed = '0;
    wait_cyc(100);
    check(vcount == v0, "R9", "released during scan", vcount - v0, 0);
    check(col_n == 4'b0000, "R9", "cols after empty scan", col_n, 0);
    pressed = 16'(1) << 12;
    wait_cyc(150);
    check(vcount == v0 + 1 && last_code == 8'h43, "R9", "recovery press", last_code, 8'h43);
    pressed = '0;
    wait_cyc(40);
  endtask

  task automatic t_held_at_reset();
    int v0;
    pressed = 16'(1) << 10;
    do_reset();
    v0 = vcount;
    wait_cyc(300);
    check(vcount == v0, "R3", "key held from reset", vcount - v0, 0);
    pressed = '0;
    wait_cyc(60);
    check(vcount == v0, "R3", "release alone", vcount - v0, 0);
    pressed = 16'(1) << 2;
    wait_cyc(150);
    check(vcount == v0 + 1 && last_code == 8'h32, "R3", "fresh press", last_code, 8'h32);
    pressed = '0;
    wait_cyc(40);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_all_keys();
    t_held();
    t_bounce();
    t_multi();
    t_scan_order();
    t_gone_in_scan();
    t_held_at_reset();
    check(width_err == 0, "R7", "final strobe width errors", width_err, 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule